// File: doc/BRIEF.md
# Dual-Period Watchdog Timer

This block supervises a host processor by watching a single kick input. Any change of level on that input, whether rising or falling, is a kick. Once reset ends, a long startup window is in force, which gives the processor time to boot. The first kick moves the block into its normal phase. From then on, each kick must arrive within a shorter normal window. If a window expires without a kick, the timeout output is raised. It stays high until the next kick clears it.

The block is normally tied to the supply sequencer's reset status. While the sequencer holds its reset, the watchdog is frozen and cleared, and it returns to the startup phase. A mode input removes this coupling, so the watchdog runs whatever the sequencer reports. A second option makes each timeout also raise a reset request for a selectable number of cycles. The startup window, the normal window and the request length are each chosen by a code. The length in cycles is a base value shifted left by that code.

Top module: `wdog_dual_period`

## Requirements
- R1: During and directly after the synchronous reset `rst`, `wdo` and `rst_req` are 0.
- R2: With no kick after reset, `wdo` rises exactly START_BASE << `start_sel` clock edges after the first edge at which `rst` is low.
- R3: A rising change and a falling change of `wdi` are both kicks. A kick takes effect at the third clock edge after the change of `wdi`.
- R4: The first kick switches the block to the normal phase. After that kick takes effect, `wdo` rises after NORM_BASE << `norm_sel` edges if no further kick arrives.
- R5: Kicks spaced closer than the normal window keep `wdo` at 0.
- R6: A kick while `wdo` is 1 clears `wdo` and restarts the normal window.
- R7: While `seq_rst` is 1 and `indep` is 0, `wdo` is 0 from the next edge and the count is held cleared. After `seq_rst` falls, the startup window applies again, counted as in R2.
- R8: While `indep` is 1, `seq_rst` has no effect, and the startup timeout of R2 still occurs.
- R9: When `rst_en` is 1, a timeout raises `rst_req` at the same edge that raises `wdo`. `rst_req` then stays 1 for exactly PULSE_BASE << `pulse_sel` cycles. When `rst_en` is 0, `rst_req` stays 0.
- R10: Without a kick, `wdo` stays at 1 and no further `rst_req` pulse is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdi | input | 1 | Asynchronous kick input; any edge is a kick |
| seq_rst | input | 1 | Sequencer reset status, 1 = reset held |
| indep | input | 1 | 1 = ignore `seq_rst` |
| rst_en | input | 1 | 1 = a timeout also raises `rst_req` |
| start_sel | input | SEL_W | Startup window code, START_BASE << code cycles |
| norm_sel | input | SEL_W | Normal window code, NORM_BASE << code cycles |
| pulse_sel | input | SEL_W | Request length code, PULSE_BASE << code cycles |
| wdo | output | 1 | Timeout flag, 1 = expired |
| rst_req | output | 1 | Reset request pulse |

## Verification
The hardest state to reach from the ports is a kick that arrives while the timeout is already raised, with the block in its normal phase. To get there, the bench first lets a kick move the block into the normal phase. It then lets the normal window run out and only afterwards toggles `wdi`, using the opposite edge polarity. The bench also has to bring about a sequencer hold that interrupts the normal phase. The hold is applied mid-run, and the bench then measures the full startup length again after release, which shows that the phase was reset and not merely the count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {PH_START = 1'b0, PH_NORM = 1'b1} wd_phase_e;

  function automatic int unsigned span_of(input int unsigned base, input int unsigned code);
    return base << code;
  endfunction
endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wdi,
  output logic kick
);
  logic [STAGES-1:0] pipe;
  logic              last;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 1'b0;
        else     pipe[0] <= wdi;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= 1'b0;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= pipe[STAGES-1];
  end

  assign kick = pipe[STAGES-1] ^ last;
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int START_BASE = 64,
  parameter int NORM_BASE  = 16,
  parameter int CNT_W      = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             held,
  input  logic             kick,
  input  logic [SEL_W-1:0] start_sel,
  input  logic [SEL_W-1:0] norm_sel,
  output logic             wdo,
  output logic             tmo
);
  wd_phase_e        phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    if (phase == PH_NORM) lim = CNT_W'(span_of(NORM_BASE, 32'(norm_sel)));
    else                  lim = CNT_W'(span_of(START_BASE, 32'(start_sel)));
  end

  assign tmo = !held && !kick && !wdo && (cnt == lim - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || held) begin
      cnt   <= '0;
      phase <= PH_START;
      wdo   <= 1'b0;
    end else if (kick) begin
      cnt   <= '0;
      phase <= PH_NORM;
      wdo   <= 1'b0;
    end else if (!wdo) begin
      if (tmo) begin
        cnt <= '0;
        wdo <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse
  import wdog_pkg::*;
#(
  parameter int SEL_W      = 3,
  parameter int PULSE_BASE = 4,
  parameter int PCNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [SEL_W-1:0] pulse_sel,
  output logic             req
);
  logic [PCNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)                left <= '0;
    else if (fire)          left <= PCNT_W'(span_of(PULSE_BASE, 32'(pulse_sel)));
    else if (left != '0)    left <= left - PCNT_W'(1);
  end

  assign req = (left != '0);
endmodule

// File: rtl/wdog_dual_period.sv
module wdog_dual_period #(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int START_BASE  = 64,
  parameter int NORM_BASE   = 16,
  parameter int PULSE_BASE  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wdi,
  input  logic             seq_rst,
  input  logic             indep,
  input  logic             rst_en,
  input  logic [SEL_W-1:0] start_sel,
  input  logic [SEL_W-1:0] norm_sel,
  input  logic [SEL_W-1:0] pulse_sel,
  output logic             wdo,
  output logic             rst_req
);
  localparam int MAX_CODE = (1 << SEL_W) - 1;
  localparam int MAX_WIN  = ((START_BASE > NORM_BASE) ? START_BASE : NORM_BASE) << MAX_CODE;
  localparam int CNT_W    = $clog2(MAX_WIN) + 1;
  localparam int PCNT_W   = $clog2(PULSE_BASE << MAX_CODE) + 1;

  logic kick;
  logic held;
  logic tmo;

  assign held = seq_rst && !indep;

  wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .wdi(wdi), .kick(kick)
  );

  wdog_window #(
    .SEL_W(SEL_W), .START_BASE(START_BASE), .NORM_BASE(NORM_BASE), .CNT_W(CNT_W)
  ) u_win (
    .clk(clk), .rst(rst), .held(held), .kick(kick),
    .start_sel(start_sel), .norm_sel(norm_sel), .wdo(wdo), .tmo(tmo)
  );

  wdog_rst_pulse #(
    .SEL_W(SEL_W), .PULSE_BASE(PULSE_BASE), .PCNT_W(PCNT_W)
  ) u_pulse (
    .clk(clk), .rst(rst), .fire(tmo && rst_en), .pulse_sel(pulse_sel), .req(rst_req)
  );
endmodule

// File: rtl/wdog_dual_period_chk.sv
module wdog_dual_period_chk #(
  parameter int SEL_W      = 3,
  parameter int PULSE_BASE = 4
) (
  input logic clk,
  input logic rst,
  input logic seq_rst,
  input logic indep,
  input logic rst_en,
  input logic kick,
  input logic held,
  input logic wdo,
  input logic rst_req
);
  localparam int MAX_PULSE = PULSE_BASE << ((1 << SEL_W) - 1);
  localparam int RUN_W     = $clog2(MAX_PULSE) + 2;

  logic [RUN_W-1:0] run;
  always_ff @(posedge clk) begin
    if (rst || !rst_req) run <= '0;
    else if (run != '1)  run <= run + RUN_W'(1);
  end

  a_r1_reset_quiet: assert property (@(posedge clk) $past(rst) |-> (!wdo && !rst_req));

  a_r7_hold_clears: assert property (@(posedge clk) disable iff (rst)
    (seq_rst && !indep) |=> !wdo);

  a_r6_wdo_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(wdo) |-> $past(kick || held));

  a_r9_req_with_timeout: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> ($rose(wdo) && $past(rst_en)));

  a_r9_req_bounded: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (run < RUN_W'(MAX_PULSE)));
endmodule

bind wdog_dual_period wdog_dual_period_chk #(.SEL_W(SEL_W), .PULSE_BASE(PULSE_BASE)) u_chk (
  .clk(clk), .rst(rst), .seq_rst(seq_rst), .indep(indep), .rst_en(rst_en),
  .kick(kick), .held(held), .wdo(wdo), .rst_req(rst_req)
);

// File: tb/wdog_dual_period_tb.sv
`timescale 1ns/1ps
module wdog_dual_period_tb;
  localparam int SEL_W = 3;
  localparam int START_BASE = 64;
  localparam int NORM_BASE = 16;
  localparam int PULSE_BASE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wdi = 1'b0;
  logic seq_rst = 1'b0;
  logic indep = 1'b0;
  logic rst_en = 1'b0;
  logic [SEL_W-1:0] start_sel = '0;
  logic [SEL_W-1:0] norm_sel = 3'd1;
  logic [SEL_W-1:0] pulse_sel = 3'd1;
  logic wdo, rst_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_dual_period #(.SEL_W(SEL_W), .START_BASE(START_BASE), .NORM_BASE(NORM_BASE),
                     .PULSE_BASE(PULSE_BASE)) u_dut (
    .clk(clk), .rst(rst), .wdi(wdi), .seq_rst(seq_rst), .indep(indep), .rst_en(rst_en),
    .start_sel(start_sel), .norm_sel(norm_sel), .pulse_sel(pulse_sel),
    .wdo(wdo), .rst_req(rst_req)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    wdi = 1'b0; rst = 1'b1;
    ticks(3);
    rst = 1'b0;
  endtask

  int ls, ln, lp;

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; wdi = 1'b0;
    ticks(3);
    check("R1", "wdo in reset", wdo, 1'b0);
    check("R1", "rst_req in reset", rst_req, 1'b0);
    rst = 1'b0;
    ticks(1);
    check("R1", "wdo after reset", wdo, 1'b0);
  endtask

  task automatic t_startup();
    rst_en = 1'b0;
    do_reset();
    ticks(ls - 1);
    check("R2", "wdo before startup end", wdo, 1'b0);
    ticks(1);
    check("R2", "wdo at startup end", wdo, 1'b1);
    check("R9", "rst_req with rst_en=0", rst_req, 1'b0);
  endtask

  task automatic t_first_kick_rise();
    do_reset();
    ticks(10);
    wdi = 1'b1;
    ticks(2 + ln);
    check("R4", "wdo before normal end", wdo, 1'b0);
    ticks(1);
    check("R3", "rising kick starts normal window", wdo, 1'b1);
  endtask

  task automatic t_kick_while_wdo();
    ticks(5);
    check("R10", "wdo stays set", wdo, 1'b1);
    wdi = 1'b0;
    ticks(2);
    check("R6", "wdo before kick lands", wdo, 1'b1);
    ticks(1);
    check("R6", "falling kick clears wdo", wdo, 1'b0);
    for (int k = 0; k < 5; k++) begin
      ticks(20);
      wdi = ~wdi;
      check("R5", "kicked window", wdo, 1'b0);
    end
    ticks(2 + ln);
    check("R5", "last window not expired", wdo, 1'b0);
    ticks(1);
    check("R6", "restarted window expires", wdo, 1'b1);
  endtask

  task automatic t_hold();
    wdi = ~wdi;
    ticks(3);
    check("R7", "kick before hold", wdo, 1'b0);
    seq_rst = 1'b1;
    ticks(ln + 50);
    check("R7", "wdo held low", wdo, 1'b0);
    seq_rst = 1'b0;
    ticks(ls - 1);
    check("R7", "startup length after hold, before end", wdo, 1'b0);
    ticks(1);
    check("R7", "startup length after hold, at end", wdo, 1'b1);
    seq_rst = 1'b1;
    ticks(1);
    check("R7", "hold drops wdo next edge", wdo, 1'b0);
    seq_rst = 1'b0;
  endtask

  task automatic t_indep();
    indep = 1'b1;
    do_reset();
    seq_rst = 1'b1;
    ticks(ls - 1);
    check("R8", "independent before end", wdo, 1'b0);
    ticks(1);
    check("R8", "independent timeout despite seq_rst", wdo, 1'b1);
    seq_rst = 1'b0;
    indep = 1'b0;
  endtask

  task automatic t_pulse();
    rst_en = 1'b1;
    do_reset();
    ticks(ls - 1);
    check("R9", "rst_req before timeout", rst_req, 1'b0);
    ticks(1);
    check("R9", "rst_req at timeout", rst_req, 1'b1);
    ticks(lp - 1);
    check("R9", "rst_req last cycle", rst_req, 1'b1);
    ticks(1);
    check("R9", "rst_req ends", rst_req, 1'b0);
    ticks(3 * ls);
    check("R10", "wdo still set", wdo, 1'b1);
    check("R10", "no second pulse", rst_req, 1'b0);
    rst_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    ls = START_BASE << start_sel;
    ln = NORM_BASE << norm_sel;
    lp = PULSE_BASE << pulse_sel;
    t_reset();
    t_startup();
    t_first_kick_rise();
    t_kick_while_wdo();
    t_hold();
    t_indep();
    t_pulse();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule